// File: doc/BRIEF.md
# Signal Strength Conversion Controller

This block decides when a received-signal-strength sample is taken and holds the result for the rest of the receive session. While the receiver is enabled it waits for an on-channel carrier that also stays above the noise floor. Once that condition has held without a break for a programmable number of clock cycles, the block sends a single-cycle start pulse to an external 5-bit converter. It then waits for the converter's done pulse and stores the returned code. A software force input can start the same conversion without any carrier, for example to measure the noise floor before transmitting.

After one conversion the controller halts, and neither carrier nor force starts another one. The only way to re-arm it is to switch receive off and back on. Switching receive off clears the valid flag and leaves the last code readable. The stored code and the valid flag are presented as one status byte. Two compare outputs flag a weak (or quiet) channel and a strong signal.

Top module: `rssi_ctrl`

## Requirements
- R1: The status byte carries the stored 5-bit code in bits 4:0 and the valid flag in bit 5. Bits 7:6 always read 0.
- R2: While reset is held, and on the first cycle after it, the status byte is 0x00 and adc_start, weak_sig and strong_sig are all 0.
- R3: Receive enable and the qualified carrier (carrier_det and above_floor both high) are presented together before a clock edge E. On edge E the block enters qualification. adc_start goes high on the QUAL_CYC-th edge after E, provided the qualified carrier stays high on every one of those edges.
- R4: One edge with carrier_det or above_floor low restarts the qualification count. adc_start then rises on the QUAL_CYC-th edge after qualification returns.
- R5: force_cd high at an edge while qualifying starts a conversion at once: adc_start goes high on that edge, with no carrier needed.
- R6: adc_start is never high for two consecutive cycles.
- R7: When adc_done is high at an edge during a conversion, adc_data is stored in bits 4:0 and the valid flag is set on that edge.
- R8: After a conversion has completed, no further adc_start occurs while receive stays enabled, whatever carrier and force do. The status byte stays unchanged.
- R9: rx_en low at an edge clears the valid flag on that edge and keeps bits 4:0. When receive is enabled again, the next conversion proceeds as in R3 or R5.
- R10: If receive drops during a conversion, a later adc_done is ignored and the valid flag stays 0.
- R11: weak_sig is high exactly when the flag is valid and the code is below WEAK_LIM (10). strong_sig is high exactly when the flag is valid and the code is above STRONG_LIM (28).
- R12: force_cd has no effect while rx_en is low: adc_start stays 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_en | input | 1 | Receive mode enable level |
| carrier_det | input | 1 | On-channel carrier detected |
| above_floor | input | 1 | Signal above noise floor |
| force_cd | input | 1 | Software force of carrier detect |
| adc_start | output | 1 | One-cycle converter start strobe |
| adc_data | input | 5 | Converter result |
| adc_done | input | 1 | Converter done strobe |
| status | output | 8 | Status byte: code, valid flag, zero bits |
| weak_sig | output | 1 | Valid code below weak limit |
| strong_sig | output | 1 | Valid code above strong limit |

## Verification
The bench builds the block with QUAL_CYC set to 8. At that size the qualification window can be measured edge by edge, and a carrier or noise-floor drop can be placed at every position inside the window. The code width and thresholds keep their defaults, so all 32 converter codes are swept, each with its own receive session. Each code is checked against both compare limits and against the clear-on-receive-off behaviour.

// File: rtl/rssi_pkg.sv
package rssi_pkg;

    localparam int VAL_W    = 5;
    localparam int STATUS_W = 8;
    localparam int VALID_BIT = VAL_W;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_QUALIFY = 2'd1,
        ST_CONVERT = 2'd2,
        ST_HALT    = 2'd3
    } conv_state_e;

    typedef struct packed {
        logic             valid;
        logic [VAL_W-1:0] code;
    } rssi_result_t;

    typedef struct packed {
        logic start;
        logic capture;
        logic clear;
    } conv_ctl_t;

    function automatic logic [STATUS_W-1:0] pack_status(rssi_result_t r);
        logic [STATUS_W-1:0] b;
        b = '0;
        b[VAL_W-1:0] = r.code;
        b[VALID_BIT] = r.valid;
        return b;
    endfunction

    function automatic logic below_lim(logic [VAL_W-1:0] v, int lim);
        return int'(v) < lim;
    endfunction

    function automatic logic above_lim(logic [VAL_W-1:0] v, int lim);
        return int'(v) > lim;
    endfunction

endpackage

// File: rtl/rssi_qual_timer.sv
module rssi_qual_timer #(
    parameter int QUAL_CYC = 650
) (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic qualified,
    output logic expired
);
    localparam int CNT_W = (QUAL_CYC > 1) ? $clog2(QUAL_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(QUAL_CYC - 1);

    logic [CNT_W-1:0] cnt;
    logic             counting;

    assign counting = enable && qualified;
    assign expired  = counting && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (!counting) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/rssi_conv_fsm.sv
module rssi_conv_fsm
    import rssi_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        rx_en,
    input  logic        force_cd,
    input  logic        qual_expired,
    input  logic        adc_done,
    output logic        qualifying,
    output logic        adc_start,
    output conv_ctl_t   ctl
);
    conv_state_e state, state_nx;
    logic        start_nx;

    assign qualifying = (state == ST_QUALIFY) && rx_en;

    always_comb begin
        state_nx = state;
        start_nx = 1'b0;
        ctl      = '0;
        if (!rx_en) begin
            state_nx  = ST_IDLE;
            ctl.clear = 1'b1;
        end else begin
            case (state)
                ST_IDLE: state_nx = ST_QUALIFY;
                ST_QUALIFY: begin
                    if (force_cd || qual_expired) begin
                        state_nx = ST_CONVERT;
                        start_nx = 1'b1;
                    end
                end
                ST_CONVERT: begin
                    if (adc_done) begin
                        state_nx    = ST_HALT;
                        ctl.capture = 1'b1;
                    end
                end
                ST_HALT: state_nx = ST_HALT;
                default: state_nx = ST_IDLE;
            endcase
        end
        ctl.start = start_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            adc_start <= 1'b0;
        end else begin
            state     <= state_nx;
            adc_start <= start_nx;
        end
    end
endmodule

// File: rtl/rssi_result_reg.sv
module rssi_result_reg
    import rssi_pkg::*;
#(
    parameter int WEAK_LIM   = 10,
    parameter int STRONG_LIM = 28
) (
    input  logic                clk,
    input  logic                rst,
    input  conv_ctl_t           ctl,
    input  logic [VAL_W-1:0]    adc_data,
    output logic [STATUS_W-1:0] status,
    output logic                weak_sig,
    output logic                strong_sig
);
    rssi_result_t res;

    always_ff @(posedge clk) begin
        if (rst) begin
            res <= '0;
        end else if (ctl.clear) begin
            res.valid <= 1'b0;
        end else if (ctl.capture) begin
            res.code  <= adc_data;
            res.valid <= 1'b1;
        end
    end

    assign status = pack_status(res);

    logic [1:0] cmp;
    genvar g;
    generate
        for (g = 0; g < 2; g++) begin : g_cmp
            if (g == 0) begin : g_weak
                assign cmp[g] = res.valid && below_lim(res.code, WEAK_LIM);
            end else begin : g_strong
                assign cmp[g] = res.valid && above_lim(res.code, STRONG_LIM);
            end
        end
    endgenerate

    assign weak_sig   = cmp[0];
    assign strong_sig = cmp[1];
endmodule

// File: rtl/rssi_ctrl.sv
module rssi_ctrl
    import rssi_pkg::*;
#(
    parameter int QUAL_CYC   = 650,
    parameter int WEAK_LIM   = 10,
    parameter int STRONG_LIM = 28
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rx_en,
    input  logic                carrier_det,
    input  logic                above_floor,
    input  logic                force_cd,
    output logic                adc_start,
    input  logic [VAL_W-1:0]    adc_data,
    input  logic                adc_done,
    output logic [STATUS_W-1:0] status,
    output logic                weak_sig,
    output logic                strong_sig
);
    logic      qualifying;
    logic      qual_expired;
    conv_ctl_t ctl;

    rssi_qual_timer #(.QUAL_CYC(QUAL_CYC)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .enable    (qualifying),
        .qualified (carrier_det && above_floor),
        .expired   (qual_expired)
    );

    rssi_conv_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .rx_en        (rx_en),
        .force_cd     (force_cd),
        .qual_expired (qual_expired),
        .adc_done     (adc_done),
        .qualifying   (qualifying),
        .adc_start    (adc_start),
        .ctl          (ctl)
    );

    rssi_result_reg #(.WEAK_LIM(WEAK_LIM), .STRONG_LIM(STRONG_LIM)) u_res (
        .clk        (clk),
        .rst        (rst),
        .ctl        (ctl),
        .adc_data   (adc_data),
        .status     (status),
        .weak_sig   (weak_sig),
        .strong_sig (strong_sig)
    );
endmodule

// File: rtl/rssi_ctrl_chk.sv
module rssi_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_en,
    input logic       force_cd,
    input logic       adc_start,
    input logic [4:0] adc_data,
    input logic       adc_done,
    input logic [7:0] status,
    input logic       weak_sig,
    input logic       strong_sig
);
    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[7:6] == 2'b00); // R1

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        adc_start |=> !adc_start); // R6

    AST_CAPTURE_CODE: assert property (@(posedge clk) disable iff (rst)
        $rose(status[5]) |-> (status[4:0] == $past(adc_data)) && $past(adc_done)); // R7

    AST_NO_START_HALTED: assert property (@(posedge clk) disable iff (rst)
        status[5] |-> !adc_start); // R8

    AST_HALT_STABLE: assert property (@(posedge clk) disable iff (rst)
        (status[5] && rx_en) |=> $stable(status)); // R8

    AST_RX_OFF_CLEARS: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !status[5] && $stable(status[4:0])); // R9

    AST_CMP_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(weak_sig && strong_sig) && ((weak_sig || strong_sig) -> status[5])); // R11

    AST_FORCE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!rx_en && force_cd) |=> !adc_start); // R12
endmodule

bind rssi_ctrl rssi_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .rx_en      (rx_en),
    .force_cd   (force_cd),
    .adc_start  (adc_start),
    .adc_data   (adc_data),
    .adc_done   (adc_done),
    .status     (status),
    .weak_sig   (weak_sig),
    .strong_sig (strong_sig)
);

// File: tb/sim_rssi_ctrl.sv
module sim_rssi_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int QUAL = 8;
    localparam int WEAK = 10;
    localparam int STRONG = 28;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_en = 1'b0;
    logic       carrier_det = 1'b0;
    logic       above_floor = 1'b0;
    logic       force_cd = 1'b0;
    logic       adc_start;
    logic [4:0] adc_data = '0;
    logic       adc_done = 1'b0;
    logic [7:0] status;
    logic       weak_sig;
    logic       strong_sig;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rssi_ctrl #(.QUAL_CYC(QUAL), .WEAK_LIM(WEAK), .STRONG_LIM(STRONG)) u0 (
        .clk(clk), .rst(rst), .rx_en(rx_en), .carrier_det(carrier_det),
        .above_floor(above_floor), .force_cd(force_cd), .adc_start(adc_start),
        .adc_data(adc_data), .adc_done(adc_done), .status(status),
        .weak_sig(weak_sig), .strong_sig(strong_sig)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // counts edges until adc_start is seen high at a negedge
    task automatic edges_to_start(output int n);
        n = 0;
        for (int i = 1; i <= 4 * QUAL + 8; i++) begin
            @(negedge clk);
            if (adc_start) begin
                n = i;
                break;
            end
        end
    endtask

    task automatic finish_conv(input logic [4:0] v);
        adc_data = v;
        adc_done = 1'b1;
        tick(1);
        adc_done = 1'b0;
        adc_data = '0;
    endtask

    task automatic rx_off;
        rx_en = 1'b0; carrier_det = 1'b0; above_floor = 1'b0; force_cd = 1'b0;
        tick(2);
    endtask

    initial begin
        tick(3);
        chk("R2 status", int'(status), 0);
        chk("R2 start", int'(adc_start), 0);
        rst = 1'b0;
        tick(1);
        chk("R2 status after", int'(status), 0);
        chk("R2 cmp", int'({weak_sig, strong_sig}), 0);

        // R3: automatic start after qualification window
        begin
            int n;
            rx_en = 1'b1; carrier_det = 1'b1; above_floor = 1'b1;
            edges_to_start(n);
            chk("R3 qual edges", n, QUAL + 1);
            tick(1);
            chk("R6 start one cycle", int'(adc_start), 0);
            finish_conv(5'd17);
            chk("R7 status", int'(status), 32 + 17);
            // R8: halt ignores carrier and force
            force_cd = 1'b1;
            for (int i = 0; i < 2 * QUAL; i++) begin
                tick(1);
                chk("R8 no start", int'(adc_start), 0);
            end
            chk("R8 status kept", int'(status), 32 + 17);
            force_cd = 1'b0;
            rx_off();
            chk("R9 valid cleared", int'(status), 17);
        end

        // R4: qualification drop at each position restarts the count
        for (int p = 1; p < QUAL; p++) begin
            int n;
            rx_en = 1'b1; carrier_det = 1'b1; above_floor = 1'b1;
            tick(p + 1);
            chk("R4 no early start", int'(adc_start), 0);
            if (p % 2 == 0) above_floor = 1'b0; else carrier_det = 1'b0;
            tick(1);
            carrier_det = 1'b1; above_floor = 1'b1;
            edges_to_start(n);
            chk("R4 restart edges", n, QUAL);
            tick(1);
            finish_conv(5'(p));
            chk("R4 status", int'(status), 32 + p);
            rx_off();
        end

        // R5: force from idle entry and from mid-qualification
        begin
            int n;
            rx_en = 1'b1; force_cd = 1'b1;
            edges_to_start(n);
            chk("R5 force from entry", n, 2);
            force_cd = 1'b0;
            tick(1);
            finish_conv(5'd3);
            rx_off();
            rx_en = 1'b1;
            tick(3);
            force_cd = 1'b1;
            edges_to_start(n);
            chk("R5 force mid", n, 1);
            force_cd = 1'b0;
            tick(1);
            finish_conv(5'd4);
            chk("R5 status", int'(status), 32 + 4);
            rx_off();
        end

        // R10: receive drop during conversion
        begin
            int n;
            rx_en = 1'b1; force_cd = 1'b1;
            edges_to_start(n);
            force_cd = 1'b0;
            rx_en = 1'b0;
            tick(1);
            finish_conv(5'd29);
            tick(1);
            chk("R10 valid", int'(status[5]), 0);
            chk("R10 code kept", int'(status[4:0]), 4);
        end

        // R12: force with receive off
        force_cd = 1'b1;
        for (int i = 0; i < 6; i++) begin
            tick(1);
            chk("R12 no start", int'(adc_start), 0);
        end
        force_cd = 1'b0;

        // R1 R7 R9 R11: exhaustive code sweep
        for (int v = 0; v < 32; v++) begin
            int n;
            rx_en = 1'b1; force_cd = 1'b1;
            edges_to_start(n);
            force_cd = 1'b0;
            tick(2);
            finish_conv(5'(v));
            chk("R1 status byte", int'(status), 32 + v);
            chk("R11 weak", int'(weak_sig), (v < WEAK) ? 1 : 0);
            chk("R11 strong", int'(strong_sig), (v > STRONG) ? 1 : 0);
            rx_en = 1'b0;
            tick(1);
            chk("R9 off status", int'(status), v);
            chk("R11 off cmp", int'({weak_sig, strong_sig}), 0);
            tick(1);
        end

        done_flag = 1'b1;
    end

    initial begin
        for (int i = 0; i < 100000; i++) begin
            @(posedge clk);
            if (done_flag) break;
        end
        if (!done_flag) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule